// File: doc/BRIEF.md
# External Interrupt Mask Register Block

This block keeps one mask bit for each of eight external interrupt request lines and lets only unmasked requests through to the priority stage that follows it. Software never overwrites the mask directly. It masks sources by writing ones to a set register and unmasks them by writing ones to a separate clear register. A zero written to either register changes nothing, so one agent can change its own sources without a read-modify-write sequence that could disturb another agent's sources.

The mask is shown as a 32-bit word. Source 0 sits in the top bit and source 7 in bit 24. The lower 24 bits are always zero. Every source starts masked after reset.

A two-bit mode input marks either group of four pins as an encoded-level input. While a group's mode bit is high, the block holds all four of that group's masks set.

Top module: `irq_mask_regs`

## Requirements
- R1: During and after a synchronous active-high reset, all eight mask bits are 1. A read of the set register returns 0xFF000000, and `req_out` is 0 whatever `req_in` is.
- R2: The mask of source i (i = 0..7) is bit 31-i of the data word, both for reads and for writes to the set and clear registers.
- R3: Bits 23..0 of `rd_data` are always 0, and the value written to those bits has no effect.
- R4: A write to the set register at word address 0x0 masks every source whose data bit is 1. Sources whose data bit is 0 keep their mask unchanged.
- R5: A write to the clear register at word address 0x1 unmasks every source whose data bit is 1. Sources whose data bit is 0 are unchanged. No other access can unmask a source.
- R6: A read of the clear register returns 0 in every bit.
- R7: `req_out[i]` is a registered copy of `req_in[i]` AND NOT mask[i], and it uses the mask held at each clock edge. A mask written at edge k therefore first affects `req_out` at edge k+1.
- R8: `rd_data` is registered. It is loaded at every edge where `rd_en` is 1, and it includes any write made at an earlier edge, so a read issued in the cycle right after a write returns the new mask. After an edge where `rd_en` is 0, `rd_data` is 0.
- R9: While `enc_mode[0]` is 1, the masks of sources 0..3 are forced to 1 at every edge and clear writes to them have no effect. `enc_mode[1]` does the same for sources 4..7.
- R10: Writes to any address other than 0x0 and 0x1 have no effect on the mask, and reads of such an address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 4 | Word address: 0x0 is the set register, 0x1 the clear register |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| enc_mode | input | 2 | Bit g marks pin group g (four sources) as an encoded-level input |
| req_in | input | 8 | Raw request lines, bit i is source i |
| req_out | output | 8 | Masked requests, registered |

## Verification
The bench builds the block with its default parameters: eight sources, a 32-bit word, groups of four and a 4-bit address. With these values the reversed bit order, the zero lower field and both encoded-level groups can all be reached from the ports. A vector table walks mixed set, clear and unmapped writes, reading back both registers and the gated outputs after each one. Directed tests then cover the one-edge delay from a mask change to `req_out`, a read issued right after a write, zero-data writes, the encoded-level group holds and idle read data.

// File: rtl/irqm_pkg.sv
`timescale 1ns/1ps
package irqm_pkg;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_SET  = 2'd1,
    SEL_CLR  = 2'd2
  } reg_sel_e;

  // Data-word bit position that carries the mask of a given source.
  function automatic int unsigned word_pos(int unsigned dw, int unsigned src);
    return dw - 1 - src;
  endfunction

  // Pin group that a source belongs to.
  function automatic int unsigned group_of(int unsigned src, int unsigned gw);
    return src / gw;
  endfunction

endpackage

// File: rtl/irqm_decode.sv
`timescale 1ns/1ps
module irqm_decode #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned SET_ADDR = 0,
  parameter int unsigned CLR_ADDR = 1
) (
  input  logic              [ADDR_W-1:0] addr,
  input  logic                           wr_en,
  output irqm_pkg::reg_sel_e             sel,
  output logic                           wr_set,
  output logic                           wr_clr
);
  import irqm_pkg::*;

  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_ADDR);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_ADDR);

  always_comb begin
    if (addr == SET_A)      sel = SEL_SET;
    else if (addr == CLR_A) sel = SEL_CLR;
    else                    sel = SEL_NONE;
  end

  assign wr_set = wr_en && (sel == SEL_SET);
  assign wr_clr = wr_en && (sel == SEL_CLR);

endmodule

// File: rtl/irqm_mask_bank.sv
`timescale 1ns/1ps
module irqm_mask_bank #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned NUM_GRP = NUM_SRC / GROUP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_set,
  input  logic               wr_clr,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [NUM_GRP-1:0] enc_mode,
  output logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] set_hit,
  output logic [NUM_SRC-1:0] clr_hit,
  output logic [NUM_SRC-1:0] force_v
);
  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned POS = irqm_pkg::word_pos(DATA_W, i);
    localparam int unsigned GRP = irqm_pkg::group_of(i, GROUP_W);
    assign set_hit[i] = wr_set & wdata[POS];
    assign clr_hit[i] = wr_clr & wdata[POS];
    assign force_v[i] = enc_mode[GRP];
  end

  // A set or a forced group wins over a clear of the same bit.
  always_ff @(posedge clk) begin
    if (rst) mask <= '1;
    else     mask <= force_v | set_hit | (mask & ~clr_hit);
  end

endmodule

// File: rtl/irqm_req_gate.sv
`timescale 1ns/1ps
module irqm_req_gate #(
  parameter int unsigned NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] req_in,
  input  logic [NUM_SRC-1:0] mask,
  output logic [NUM_SRC-1:0] req_out
);
  always_ff @(posedge clk) begin
    if (rst) req_out <= '0;
    else     req_out <= req_in & ~mask;
  end
endmodule

// File: rtl/irqm_read_mux.sv
`timescale 1ns/1ps
module irqm_read_mux #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rd_en,
  input  irqm_pkg::reg_sel_e sel,
  input  logic [NUM_SRC-1:0] mask,
  output logic [DATA_W-1:0]  rd_data
);
  import irqm_pkg::*;

  logic [DATA_W-1:0] mask_word;

  always_comb begin
    mask_word = '0;
    for (int i = 0; i < NUM_SRC; i++) mask_word[word_pos(DATA_W, i)] = mask[i];
  end

  // The clear register reads as zero, as does any unmapped address.
  always_ff @(posedge clk) begin
    if (rst)                          rd_data <= '0;
    else if (rd_en && sel == SEL_SET) rd_data <= mask_word;
    else                              rd_data <= '0;
  end
endmodule

// File: rtl/irq_mask_regs.sv
`timescale 1ns/1ps
module irq_mask_regs #(
  parameter int unsigned NUM_SRC  = 8,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned GROUP_W  = 4,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned SET_ADDR = 0,
  parameter int unsigned CLR_ADDR = 1,
  localparam int unsigned NUM_GRP = NUM_SRC / GROUP_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_GRP-1:0] enc_mode,
  input  logic [NUM_SRC-1:0] req_in,
  output logic [NUM_SRC-1:0] req_out
);
  irqm_pkg::reg_sel_e sel;
  logic               wr_set;
  logic               wr_clr;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] set_hit;
  logic [NUM_SRC-1:0] clr_hit;
  logic [NUM_SRC-1:0] force_v;

  irqm_decode #(.ADDR_W(ADDR_W), .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)) u_dec (
    .addr(addr), .wr_en(wr_en), .sel(sel), .wr_set(wr_set), .wr_clr(wr_clr)
  );

  irqm_mask_bank #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .GROUP_W(GROUP_W)) u_bank (
    .clk(clk), .rst(rst), .wr_set(wr_set), .wr_clr(wr_clr), .wdata(wdata),
    .enc_mode(enc_mode), .mask(mask_q), .set_hit(set_hit), .clr_hit(clr_hit),
    .force_v(force_v)
  );

  irqm_req_gate #(.NUM_SRC(NUM_SRC)) u_gate (
    .clk(clk), .rst(rst), .req_in(req_in), .mask(mask_q), .req_out(req_out)
  );

  irqm_read_mux #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .sel(sel), .mask(mask_q), .rd_data(rd_data)
  );

endmodule

// File: rtl/irq_mask_chk.sv
`timescale 1ns/1ps
module irq_mask_chk #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned GROUP_W = 4,
  localparam int unsigned NUM_GRP = NUM_SRC / GROUP_W
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_GRP-1:0] enc_mode,
  input logic [NUM_SRC-1:0] req_in,
  input logic [NUM_SRC-1:0] req_out,
  input logic               rd_en,
  input logic [DATA_W-1:0]  rd_data,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] set_hit,
  input logic [NUM_SRC-1:0] clr_hit
);
  // R4: a set hit leaves its bit masked after the edge
  a_r4_set_sticks: assert property (@(posedge clk) disable iff (rst)
    (set_hit != '0) |=> ((mask & $past(set_hit)) == $past(set_hit)));

  // R5: a mask bit only drops where a clear hit was present
  a_r5_clear_only_path: assert property (@(posedge clk) disable iff (rst)
    (($past(mask) & ~mask & ~$past(clr_hit)) == '0));

  // R7: no masked source and no idle line reaches the output
  a_r7_out_gated: assert property (@(posedge clk) disable iff (rst)
    ((req_out & $past(mask)) == '0) && ((req_out & ~$past(req_in)) == '0));

  // R3: low field of the read word stays zero
  a_r3_low_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[DATA_W-NUM_SRC-1:0] == '0);

  // R8: read data returns to zero after an idle read cycle
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rd_data == '0));

  // R9: a group in encoded-level mode is fully masked after the edge
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    a_r9_group_held: assert property (@(posedge clk) disable iff (rst)
      enc_mode[g] |=> (&mask[g*GROUP_W +: GROUP_W]));
  end
endmodule

bind irq_mask_regs irq_mask_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .GROUP_W(GROUP_W)
) u_chk (
  .clk(clk), .rst(rst), .enc_mode(enc_mode), .req_in(req_in), .req_out(req_out),
  .rd_en(rd_en), .rd_data(rd_data), .mask(mask_q), .set_hit(set_hit),
  .clr_hit(clr_hit)
);

// File: tb/sim_irq_mask_regs.sv
`timescale 1ns/1ps
module sim_irq_mask_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  addr;
  logic        wr_en;
  logic [31:0] wdata;
  logic        rd_en;
  logic [31:0] rd_data;
  logic [1:0]  enc_mode;
  logic [7:0]  req_in;
  logic [7:0]  req_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  localparam logic [3:0] A_SET = 4'h0;
  localparam logic [3:0] A_CLR = 4'h1;

  always #2 clk = ~clk;

  irq_mask_regs u0 (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rd_data(rd_data), .enc_mode(enc_mode),
    .req_in(req_in), .req_out(req_out)
  );

  // {address, write data, expected set-register read after the write}
  localparam int NV = 8;
  localparam logic [67:0] VEC [NV] = '{
    {A_CLR, 32'hFF00_0000, 32'h0000_0000},  // R5 clear all
    {A_SET, 32'h8000_0000, 32'h8000_0000},  // R2 source 0 at bit 31
    {A_SET, 32'h00FF_FFFF, 32'h8000_0000},  // R3/R4 low bits and zeros ignored
    {A_CLR, 32'h8000_0001, 32'h0000_0000},  // R5
    {A_SET, 32'h0F00_0000, 32'h0F00_0000},  // R2 sources 4..7
    {4'h7,  32'hFFFF_FFFF, 32'h0F00_0000},  // R10 unmapped write
    {A_CLR, 32'h0500_0000, 32'h0A00_0000},  // R5 partial clear
    {A_SET, 32'hA000_0000, 32'hAA00_0000}   // R4 partial set
  };

  // Outputs expected from the mask word: source k reads bit 31-k.
  function automatic logic [7:0] gated(logic [31:0] word, logic [7:0] req);
    logic [7:0] r;
    for (int k = 0; k < 8; k++) r[k] = req[k] && !word[31-k];
    return r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic do_read(logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    v = rd_data; rd_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    rst = 1'b1; addr = '0; wr_en = 1'b0; wdata = '0; rd_en = 1'b0;
    enc_mode = '0; req_in = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 req_out in reset", {24'h0, req_out}, 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 req_out after reset", {24'h0, req_out}, 32'h0);
    do_read(A_SET, v);
    chk("R1 reset mask word", v, 32'hFF00_0000);

    for (int n = 0; n < NV; n++) begin
      do_write(VEC[n][67:64], VEC[n][63:32]);
      do_read(A_SET, v);
      chk("R2/R4/R5/R10 table mask word", v, VEC[n][31:0]);
      chk("R3 table low field", {8'h0, v[23:0]}, 32'h0);
      chk("R7 table gated outputs", {24'h0, req_out}, {24'h0, gated(VEC[n][31:0], 8'hFF)});
      do_read(A_CLR, v);
      chk("R6 clear register reads zero", v, 32'h0);
    end

    // R8: read data idles at zero
    @(negedge clk);
    chk("R8 idle read data", rd_data, 32'h0);

    // R7: one edge from mask change to output
    do_write(A_CLR, 32'hFF00_0000);
    @(negedge clk);
    chk("R7 all pass", {24'h0, req_out}, 32'hFF);
    do_write(A_SET, 32'h8000_0000);
    chk("R7 old mask at write edge", {24'h0, req_out}, 32'hFF);
    @(negedge clk);
    chk("R7 new mask one edge later", {24'h0, req_out}, 32'hFE);
    req_in = 8'h55;
    @(negedge clk);
    chk("R7 pattern 55", {24'h0, req_out}, 32'h54);
    req_in = 8'hFF;

    // R8: read right after a write
    do_write(A_CLR, 32'h8000_0000);
    do_read(A_SET, v);
    chk("R8 read after write", v, 32'h0);

    // R9: group 0 held masked, clear ignored
    @(negedge clk); enc_mode = 2'b01;
    do_write(A_CLR, 32'hFF00_0000);
    do_read(A_SET, v);
    chk("R9 group 0 held", v, 32'hF000_0000);
    chk("R9 group 0 outputs", {24'h0, req_out}, 32'hF0);
    @(negedge clk); enc_mode = 2'b00;
    do_write(A_CLR, 32'hFF00_0000);
    do_read(A_SET, v);
    chk("R9 release then clear", v, 32'h0);
    @(negedge clk); enc_mode = 2'b10;
    do_read(A_SET, v);
    chk("R9 group 1 held", v, 32'h0F00_0000);
    @(negedge clk);
    chk("R9 group 1 outputs", {24'h0, req_out}, 32'h0F);
    enc_mode = 2'b00;

    // R5: zero data to the clear register changes nothing
    do_write(A_CLR, 32'h0);
    do_read(A_SET, v);
    chk("R5 zero clear no effect", v, 32'h0F00_0000);

    // R4: zero data to the set register changes nothing
    do_write(A_SET, 32'h0);
    do_read(A_SET, v);
    chk("R4 zero set no effect", v, 32'h0F00_0000);

    // R10: unmapped read returns zero
    do_read(4'h9, v);
    chk("R10 unmapped read", v, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule